// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns the addressing part of an interrupt message into the set of receivers that should take it. A request carries an 8-bit destination, a bit choosing physical or logical addressing, a 2-bit shorthand and the index of the sender. The block holds a table with one entry per receiver. Each entry has a present flag, a physical ID, a logical ID and a 4-bit addressing model. All entries are compared in parallel, and the result is an N-bit delivery mask.

The request also carries a 3-bit delivery mode. From the mode and the mask the block builds a final target mask. For lowest-priority delivery that mask keeps only the lowest-numbered receiver. The table is loaded through a one-entry-per-cycle write port. A request is resolved against the table as it stands at that clock edge, and both masks appear registered one cycle later.

Top module: `irq_dest_resolver`

## Requirements
- R1: Shorthand code 1 (self) selects only the receiver whose index equals `req_self`, and the destination field is ignored.
- R2: Shorthand code 2 selects every receiver, the sender included. Shorthand code 3 selects every receiver except the sender.
- R3: With shorthand code 0 and physical addressing (`req_logical`=0), destination 0xFF selects every receiver.
- R4: With shorthand code 0 and physical addressing, any other destination selects each receiver whose physical ID equals it. A destination that matches no ID gives an all-zero mask.
- R5: With shorthand code 0 and logical addressing, a receiver with model 0xF (flat) matches when destination AND logical ID is nonzero.
- R6: With shorthand code 0 and logical addressing, a receiver with model 0x0 (cluster) matches when the upper nibbles of the destination and the logical ID are equal and their lower nibbles share a set bit.
- R7: In logical addressing, a receiver whose model is neither 0xF nor 0x0 never matches.
- R8: A receiver whose table entry is absent never appears in either mask, whatever the shorthand or addressing.
- R9: Delivery mode code 1 (lowest priority) makes `out_final` the lowest set bit of `out_mask`. Reserved code 3 makes `out_final` zero. Codes 0, 2, 4, 5, 6 and 7 make `out_final` equal to `out_mask`.
- R10: A request with `req_valid` high raises `out_valid` with both masks one cycle later. With no request, `out_valid` is low and both masks hold their values.
- R11: A table write is seen by requests from the next cycle on. A request issued in the same cycle as a write resolves against the old contents.
- R12: Synchronous reset clears `out_valid`, both masks and every present flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W (3) | Entry written |
| wr_present | input | 1 | Present flag for the entry |
| wr_phys_id | input | 8 | Physical ID for the entry |
| wr_log_id | input | 8 | Logical ID for the entry |
| wr_model | input | 4 | Addressing model for the entry (0xF flat, 0x0 cluster) |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| req_self | input | IDX_W (3) | Sender index |
| req_mode | input | 3 | Delivery mode code |
| out_valid | output | 1 | Result strobe |
| out_mask | output | NUM_RX (8) | Resolved delivery mask |
| out_final | output | NUM_RX (8) | Target mask after delivery-mode handling |

## Verification
All state lives in the table and the output registers. A wrong internal state therefore shows up on `out_mask` in the cycle after the first request that addresses the affected entry. A stale present flag shows as a bit set for a receiver that is absent. A corrupted logical ID or model appears only under logical addressing, so the vectors use both flat and cluster receivers with overlapping and disjoint nibbles. A bad pick in lowest-priority mode shows in `out_final` in the same cycle as the mask it came from.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

  localparam int ID_W    = 8;
  localparam int MODEL_W = 4;
  localparam int NIB_W   = ID_W / 2;
  localparam int MODE_W  = 3;

  localparam logic [ID_W-1:0]    PHYS_BCAST    = '1;
  localparam logic [MODEL_W-1:0] MODEL_FLAT    = '1;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = '0;

  localparam logic [MODE_W-1:0] DM_LOWEST = 3'd1;
  localparam logic [MODE_W-1:0] DM_RSVD   = 3'd3;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [ID_W-1:0]    phys_id;
    logic [ID_W-1:0]    log_id;
    logic [MODEL_W-1:0] model;
  } rx_entry_t;

endpackage

// File: rtl/rx_table.sv
module rx_table
  import irq_dest_pkg::*;
#(
  parameter int NUM_RX = 8,
  parameter int IDX_W  = (NUM_RX > 1) ? $clog2(NUM_RX) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic                    wr_present,
  input  rx_entry_t               wr_entry,
  output rx_entry_t [NUM_RX-1:0]  entries,
  output logic [NUM_RX-1:0]       present_vec
);

  for (genvar g = 0; g < NUM_RX; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    // presence flag is the only reset state; entry bodies need none
    always_ff @(posedge clk) begin
      if (rst)      present_vec[g] <= 1'b0;
      else if (hit) present_vec[g] <= wr_present;
    end

    always_ff @(posedge clk) begin
      if (hit) entries[g] <= wr_entry;
    end
  end

endmodule

// File: rtl/rx_match.sv
module rx_match
  import irq_dest_pkg::*;
#(
  parameter int NUM_RX = 8,
  parameter int IDX_W  = (NUM_RX > 1) ? $clog2(NUM_RX) : 1
) (
  input  rx_entry_t [NUM_RX-1:0] entries,
  input  logic [NUM_RX-1:0]      present_vec,
  input  logic [ID_W-1:0]        dest,
  input  logic                   logical,
  input  shorthand_e             shorthand,
  input  logic [IDX_W-1:0]       self_idx,
  output logic [NUM_RX-1:0]      match_vec
);

  for (genvar g = 0; g < NUM_RX; g++) begin : g_cmp
    logic phys_hit, flat_hit, clus_hit, field_hit, is_self, sel;

    always_comb begin
      phys_hit = (dest == PHYS_BCAST) || (entries[g].phys_id == dest);
      flat_hit = (entries[g].model == MODEL_FLAT) &&
                 (|(dest & entries[g].log_id));
      clus_hit = (entries[g].model == MODEL_CLUSTER) &&
                 (dest[ID_W-1:NIB_W] == entries[g].log_id[ID_W-1:NIB_W]) &&
                 (|(dest[NIB_W-1:0] & entries[g].log_id[NIB_W-1:0]));
      field_hit = logical ? (flat_hit || clus_hit) : phys_hit;
      is_self   = (self_idx == IDX_W'(g));
      unique case (shorthand)
        SH_FIELD:  sel = field_hit;
        SH_SELF:   sel = is_self;
        SH_ALL:    sel = 1'b1;
        SH_OTHERS: sel = !is_self;
        default:   sel = 1'b0;
      endcase
      match_vec[g] = present_vec[g] && sel;
    end
  end

endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int NUM_RX = 8
) (
  input  logic [NUM_RX-1:0] vec,
  output logic [NUM_RX-1:0] pick
);

  // isolate lowest set bit: vec AND its two's complement
  assign pick = vec & (~vec + NUM_RX'(1));

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int NUM_RX = 8,
  parameter int IDX_W  = (NUM_RX > 1) ? $clog2(NUM_RX) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_present,
  input  logic [ID_W-1:0]     wr_phys_id,
  input  logic [ID_W-1:0]     wr_log_id,
  input  logic [MODEL_W-1:0]  wr_model,
  input  logic                req_valid,
  input  logic [ID_W-1:0]     req_dest,
  input  logic                req_logical,
  input  logic [1:0]          req_shorthand,
  input  logic [IDX_W-1:0]    req_self,
  input  logic [MODE_W-1:0]   req_mode,
  output logic                out_valid,
  output logic [NUM_RX-1:0]   out_mask,
  output logic [NUM_RX-1:0]   out_final
);

  rx_entry_t [NUM_RX-1:0] entries;
  logic [NUM_RX-1:0]      present_vec;
  logic [NUM_RX-1:0]      match_vec;
  logic [NUM_RX-1:0]      pick_vec;
  logic [NUM_RX-1:0]      final_next;
  rx_entry_t              wr_entry;

  assign wr_entry = '{phys_id: wr_phys_id, log_id: wr_log_id, model: wr_model};

  rx_table #(.NUM_RX(NUM_RX), .IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_present (wr_present),
    .wr_entry   (wr_entry),
    .entries    (entries),
    .present_vec(present_vec)
  );

  rx_match #(.NUM_RX(NUM_RX), .IDX_W(IDX_W)) u_match (
    .entries    (entries),
    .present_vec(present_vec),
    .dest       (req_dest),
    .logical    (req_logical),
    .shorthand  (shorthand_e'(req_shorthand)),
    .self_idx   (req_self),
    .match_vec  (match_vec)
  );

  lowest_pick #(.NUM_RX(NUM_RX)) u_pick (
    .vec (match_vec),
    .pick(pick_vec)
  );

  always_comb begin
    if (req_mode == DM_LOWEST)    final_next = pick_vec;
    else if (req_mode == DM_RSVD) final_next = '0;
    else                          final_next = match_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_final <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_mask  <= match_vec;
        out_final <= final_next;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && $stable(out_mask) && $stable(out_final)));

  assert_absent_excluded_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_mask & ~$past(present_vec)) == '0));

  assert_lowest_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(req_mode) == DM_LOWEST)) |->
      ($onehot0(out_final) && ((out_final & ~out_mask) == '0) &&
       ((out_mask == '0) == (out_final == '0))));

  assert_others_skip_self_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(req_shorthand) == 2'd3)) |-> !out_mask[$past(req_self)]);

  assert_self_single_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(req_shorthand) == 2'd1)) |-> ($countones(out_mask) <= 1));

endmodule

// File: tb/irq_dest_resolver_bench.sv
module irq_dest_resolver_bench;

  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_idx = '0;
  logic       wr_present = 1'b0;
  logic [7:0] wr_phys_id = '0;
  logic [7:0] wr_log_id = '0;
  logic [3:0] wr_model = '0;
  logic       req_valid = 1'b0;
  logic [7:0] req_dest = '0;
  logic       req_logical = 1'b0;
  logic [1:0] req_shorthand = '0;
  logic [2:0] req_self = '0;
  logic [2:0] req_mode = '0;
  logic       out_valid;
  logic [N-1:0] out_mask, out_final;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_dest_resolver #(.NUM_RX(N)) u_irq_dest_resolver (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_present(wr_present),
    .wr_phys_id(wr_phys_id), .wr_log_id(wr_log_id), .wr_model(wr_model),
    .req_valid(req_valid), .req_dest(req_dest), .req_logical(req_logical),
    .req_shorthand(req_shorthand), .req_self(req_self), .req_mode(req_mode),
    .out_valid(out_valid), .out_mask(out_mask), .out_final(out_final)
  );

  typedef struct packed {
    logic [7:0] dest;
    logic       lg;
    logic [1:0] sh;
    logic [2:0] slf;
    logic [2:0] mode;
    logic [7:0] mask;
    logic [7:0] fin;
    logic [3:0] req;
  } vec_t;

  // table: 0 {p00,l01,F} 1 {p05,l02,F} 2 {p03,l12,0} 3 absent {p07,lFF,F}
  //        4 {p20,l14,0} 5 {p21,l24,0} 6 {p06,l80,F} 7 {p40,l0C,5}
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'h05, 1'b0, 2'd0, 3'd0, 3'd0, 8'h02, 8'h02, 4'd4},  // R4 single ID
    '{8'hFF, 1'b0, 2'd0, 3'd0, 3'd0, 8'hF7, 8'hF7, 4'd3},  // R3 broadcast
    '{8'h07, 1'b0, 2'd0, 3'd0, 3'd0, 8'h00, 8'h00, 4'd8},  // R8 absent ID
    '{8'h99, 1'b0, 2'd0, 3'd0, 3'd0, 8'h00, 8'h00, 4'd4},  // R4 no match
    '{8'h81, 1'b1, 2'd0, 3'd0, 3'd0, 8'h41, 8'h41, 4'd5},  // R5 flat
    '{8'h16, 1'b1, 2'd0, 3'd0, 3'd1, 8'h16, 8'h02, 4'd6},  // R6 cluster + lowest
    '{8'h10, 1'b1, 2'd0, 3'd0, 3'd0, 8'h00, 8'h00, 4'd6},  // R6 empty low nibble
    '{8'h0C, 1'b1, 2'd0, 3'd0, 3'd0, 8'h00, 8'h00, 4'd7},  // R7 odd model
    '{8'h05, 1'b0, 2'd1, 3'd4, 3'd0, 8'h10, 8'h10, 4'd1},  // R1 self
    '{8'h05, 1'b0, 2'd1, 3'd3, 3'd0, 8'h00, 8'h00, 4'd8},  // R8 self absent
    '{8'h00, 1'b0, 2'd2, 3'd1, 3'd0, 8'hF7, 8'hF7, 4'd2},  // R2 all
    '{8'h00, 1'b0, 2'd3, 3'd0, 3'd1, 8'hF6, 8'h02, 4'd2},  // R2 others
    '{8'h00, 1'b0, 2'd2, 3'd0, 3'd1, 8'hF7, 8'h01, 4'd9},  // R9 lowest
    '{8'hFF, 1'b0, 2'd0, 3'd0, 3'd3, 8'hF7, 8'h00, 4'd9},  // R9 reserved
    '{8'h81, 1'b1, 2'd0, 3'd0, 3'd2, 8'h41, 8'h41, 4'd9},  // R9 pass-through
    '{8'h00, 1'b0, 2'd3, 3'd5, 3'd1, 8'hD7, 8'h01, 4'd2},  // R2 others, R9
    '{8'h00, 1'b0, 2'd0, 3'd0, 3'd7, 8'h01, 8'h01, 4'd4}   // R4 ID zero
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp,
                       input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic write_entry(input logic [2:0] idx, input logic pres,
                             input logic [7:0] ph, input logic [7:0] lg,
                             input logic [3:0] md);
    wr_en = 1'b1; wr_idx = idx; wr_present = pres;
    wr_phys_id = ph; wr_log_id = lg; wr_model = md;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    req_dest = v.dest; req_logical = v.lg; req_shorthand = v.sh;
    req_self = v.slf; req_mode = v.mode; req_valid = 1'b1;
  endtask

  task automatic apply(input vec_t v);
    drive(v);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check({7'd0, out_valid}, 8'h01, 10, "out_valid");
    check(out_mask, v.mask, int'(v.req), "out_mask");
    check(out_final, v.fin, int'(v.req), "out_final");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check({7'd0, out_valid}, 8'h00, 12, "out_valid after reset");
    check(out_mask, 8'h00, 12, "out_mask after reset");
    check(out_final, 8'h00, 12, "out_final after reset");
    // R12 table empty after reset: broadcast reaches nobody
    apply('{8'hFF, 1'b0, 2'd2, 3'd0, 3'd0, 8'h00, 8'h00, 4'd12});

    write_entry(3'd0, 1'b1, 8'h00, 8'h01, 4'hF);
    write_entry(3'd1, 1'b1, 8'h05, 8'h02, 4'hF);
    write_entry(3'd2, 1'b1, 8'h03, 8'h12, 4'h0);
    write_entry(3'd3, 1'b0, 8'h07, 8'hFF, 4'hF);
    write_entry(3'd4, 1'b1, 8'h20, 8'h14, 4'h0);
    write_entry(3'd5, 1'b1, 8'h21, 8'h24, 4'h0);
    write_entry(3'd6, 1'b1, 8'h06, 8'h80, 4'hF);
    write_entry(3'd7, 1'b1, 8'h40, 8'h0C, 4'h5);

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R10 idle cycle: outputs hold, valid low
    req_dest = 8'hFF; req_shorthand = 2'd2; req_mode = 3'd0;
    @(posedge clk); @(negedge clk);
    check({7'd0, out_valid}, 8'h00, 10, "idle out_valid");
    check(out_mask, 8'h01, 10, "idle out_mask hold");
    check(out_final, 8'h01, 10, "idle out_final hold");

    // R11 entry 3 made present, then reachable by its ID
    write_entry(3'd3, 1'b1, 8'h07, 8'hFF, 4'hF);
    apply('{8'h07, 1'b0, 2'd0, 3'd0, 3'd0, 8'h08, 8'h08, 4'd11});

    // R11 write in the same cycle as a request: request sees old entry
    wr_en = 1'b1; wr_idx = 3'd3; wr_present = 1'b0;
    wr_phys_id = 8'h07; wr_log_id = 8'hFF; wr_model = 4'hF;
    apply('{8'h07, 1'b0, 2'd0, 3'd0, 3'd0, 8'h08, 8'h08, 4'd11});
    wr_en = 1'b0;
    // R8 entry now absent
    apply('{8'h07, 1'b0, 2'd0, 3'd0, 3'd0, 8'h00, 8'h00, 4'd8});

    // R12 reset mid-run clears table and outputs
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check(out_mask, 8'h00, 12, "out_mask after second reset");
    apply('{8'h00, 1'b0, 2'd2, 3'd0, 3'd0, 8'h00, 8'h00, 4'd12});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule